// File: doc/BRIEF.md
# Calibration Register Pointer Sequencer

This block holds a bank of ten 14-bit trim registers for a converter: one gain trim, one offset trim and eight DAC trims. Software reaches the bank through a serial port. That port writes 16-bit words, each made of a 2-bit address and 14 data bits, and it reads 16-bit words. No register in the bank has an address of its own. A 2-bit selection field in the control word picks a subset of the bank. An internal pointer then walks through that subset, moving one register per data access.

The pointer goes back to the first register of the subset whenever a control word is written. This also happens when the new selection equals the old one, so software can abandon a walk partway. The pointer also returns to the first register on its own after the last register of the subset has been accessed. The first register is the gain trim for every selection except offset-only, which starts and stays at the offset trim.

Reads and writes share the one pointer. A read moves the pointer only while the control word's read-source field selects the calibration bank. The trim values are driven out in parallel for use by the converter datapath.

Top module: `cal_ptr_seq`

## Requirements
- R1: After reset, the pointer is at index 0, which is the gain trim. The gain and offset trims hold 0x2000, every DAC trim holds 0, and the selection and read-source fields are both 00.
- R2: Register indices are: 0 for gain, 1 for offset, 2 to 9 for DAC 1 to 8. A write to address 11 is a control word. Its bits [1:0] are the selection and its bits [3:2] are the read source. One cycle after a control word, the pointer is 1 if the new selection is 10, and 0 otherwise.
- R3: With selection 00, successive accesses visit indices 0,1,...,9. The access to index 9 returns the pointer to 0.
- R4: With selection 01, accesses visit index 0, then index 1, then return to 0.
- R5: With selection 10, the pointer stays at 1 (offset only). With selection 11, it stays at 0 (gain only).
- R6: A write to address 01 stores its 14 data bits into the register at the pointer and counts as one access.
- R7: A read strobe counts as an access only while the read source is 10. With any other read source, a read leaves the pointer unchanged.
- R8: rd_data always shows two zero bits on top of the 14 bits of the register at the pointer.
- R9: A control word written partway through a walk resets the pointer as in R2, even when the selection is unchanged.
- R10: Writes to addresses 00 and 10 change neither the pointer nor any trim register.
- R11: A counted read in the same cycle as an address-01 write moves the pointer by one step, not two. A control word in the same cycle as a read takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | A complete serial write word is present this cycle |
| wr_addr | input | 2 | Address bits of the write word |
| wr_data | input | 14 | Data bits of the write word |
| rd_en | input | 1 | A serial read word completes this cycle |
| rd_data | output | 16 | Read word: two zeros, then the pointed register |
| cal_ptr | output | 4 | Current pointer index |
| gain_trim | output | 14 | Gain trim register |
| offset_trim | output | 14 | Offset trim register |
| dac_trim | output | 112 | DAC trims 1..8, DAC 1 in the low bits |

## Verification
A wrong pointer shows up directly on cal_ptr and on rd_data in the cycle after the faulty access. A wrong start or wrap point therefore appears by the end of one walk through the subset, which is at most ten accesses. A wrong write target is silent until that register is read back or seen on the parallel trim outputs. For that reason the bench compares the whole bank against its model after every step.

// File: rtl/cal_ptr_seq.sv
module cal_ptr_seq #(
  parameter int DW = 14,
  parameter int NDAC = 8,
  parameter logic [1:0] ADDR_CTL = 2'b11,
  parameter logic [1:0] ADDR_CAL = 2'b01,
  parameter int SEL_LSB = 0,
  parameter int RSRC_LSB = 2,
  parameter logic [1:0] RSRC_CAL = 2'b10,
  parameter logic [DW-1:0] GAIN_RST = 14'h2000,
  parameter logic [DW-1:0] OFS_RST = 14'h2000,
  parameter logic [DW-1:0] DAC_RST = '0,
  localparam int NREG = NDAC + 2,
  localparam int PW = $clog2(NREG),
  localparam int RW = DW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic                 rd_en,
  output logic [RW-1:0]        rd_data,
  output logic [PW-1:0]        cal_ptr,
  output logic [DW-1:0]        gain_trim,
  output logic [DW-1:0]        offset_trim,
  output logic [NDAC*DW-1:0]   dac_trim
);

  logic [1:0] sel_q, rsrc_q;
  logic [NREG*DW-1:0] bank;

  wire ctl_wr = wr_en && (wr_addr == ADDR_CTL);
  wire cal_wr = wr_en && (wr_addr == ADDR_CAL);
  wire cal_rd = rd_en && (rsrc_q == RSRC_CAL);
  wire step   = cal_wr || cal_rd;
  wire [1:0] new_sel = wr_data[SEL_LSB +: 2];

  function automatic logic [PW-1:0] first_of(input logic [1:0] s);
    return (s == 2'b10) ? PW'(1) : PW'(0);
  endfunction

  function automatic logic [PW-1:0] last_of(input logic [1:0] s);
    case (s)
      2'b00:   return PW'(NREG - 1);
      2'b01:   return PW'(1);
      2'b10:   return PW'(1);
      default: return PW'(0);
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 2'b00;
      rsrc_q  <= 2'b00;
      cal_ptr <= '0;
    end else if (ctl_wr) begin
      sel_q   <= new_sel;
      rsrc_q  <= wr_data[RSRC_LSB +: 2];
      cal_ptr <= first_of(new_sel);
    end else if (step) begin
      cal_ptr <= (cal_ptr == last_of(sel_q)) ? first_of(sel_q) : cal_ptr + PW'(1);
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_trim
    localparam logic [DW-1:0] RV = (g == 0) ? GAIN_RST : (g == 1) ? OFS_RST : DAC_RST;
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RV;
      else if (cal_wr && cal_ptr == PW'(g)) q <= wr_data;
    end
    assign bank[g*DW +: DW] = q;
  end

  wire in_range = (32'(cal_ptr) < NREG);
  assign rd_data     = in_range ? {2'b00, bank[32'(cal_ptr)*DW +: DW]} : '0;
  assign gain_trim   = bank[0 +: DW];
  assign offset_trim = bank[DW +: DW];
  assign dac_trim    = bank[NREG*DW-1 : 2*DW];

endmodule

// File: rtl/cal_ptr_seq_chk.sv
module cal_ptr_seq_chk #(
  parameter int NREG = 10,
  parameter int PW = 4,
  parameter int DW = 14,
  parameter logic [1:0] ADDR_CTL = 2'b11,
  parameter logic [1:0] ADDR_CAL = 2'b01,
  parameter int SEL_LSB = 0,
  parameter logic [1:0] RSRC_CAL = 2'b10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          rd_en,
  input logic [1:0]    sel_q,
  input logic [1:0]    rsrc_q,
  input logic [PW-1:0] cal_ptr,
  input logic [DW+1:0] rd_data
);
  // R2
  ctl_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_CTL) |=>
      cal_ptr == (($past(wr_data[SEL_LSB +: 2]) == 2'b10) ? PW'(1) : PW'(0)));
  // R3
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cal_ptr) < NREG);
  // R5
  gain_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == 2'b11 && !(wr_en && wr_addr == ADDR_CTL)) |=> cal_ptr == '0);
  // R7
  rd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rd_en && rsrc_q != RSRC_CAL) |=> $stable(cal_ptr));
  // R8
  lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DW+1:DW] == 2'b00);
  // R10
  other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != ADDR_CTL && wr_addr != ADDR_CAL && !(rd_en && rsrc_q == RSRC_CAL))
      |=> ($stable(cal_ptr) && $stable(rd_data)));
endmodule

bind cal_ptr_seq cal_ptr_seq_chk #(
  .NREG(NREG), .PW(PW), .DW(DW), .ADDR_CTL(ADDR_CTL), .ADDR_CAL(ADDR_CAL),
  .SEL_LSB(SEL_LSB), .RSRC_CAL(RSRC_CAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .sel_q(sel_q), .rsrc_q(rsrc_q), .cal_ptr(cal_ptr), .rd_data(rd_data)
);

// File: tb/sim_cal_ptr_seq.sv
`timescale 1ns/1ps
module sim_cal_ptr_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] wr_addr = 2'b00;
  logic [13:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [3:0] cal_ptr;
  logic [13:0] gain_trim, offset_trim;
  logic [111:0] dac_trim;

  int checks = 0, failures = 0;
  logic [13:0] m_reg [10];
  int m_ptr, m_sel, m_rsrc;

  always #2 clk = ~clk;

  cal_ptr_seq u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .cal_ptr(cal_ptr),
    .gain_trim(gain_trim), .offset_trim(offset_trim), .dac_trim(dac_trim));

  function automatic int first_of(input int s);
    return (s == 2) ? 1 : 0;
  endfunction
  function automatic int last_of(input int s);
    return (s == 0) ? 9 : (s == 3) ? 0 : 1;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, cal_ptr, m_ptr);
    chk(req, rd_data, {2'b00, m_reg[m_ptr]});
    chk(req, gain_trim, m_reg[0]);
    chk(req, offset_trim, m_reg[1]);
    for (int i = 0; i < 8; i++) chk(req, dac_trim[i*14 +: 14], m_reg[i+2]);
  endtask

  // one cycle: we/addr/data and rd, then model update and compare
  task automatic op(input string req, input bit we, input logic [1:0] a,
                    input logic [13:0] d, input bit re);
    bit counted;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; rd_en = re;
    @(posedge clk);
    #1;
    wr_en = 1'b0; rd_en = 1'b0;
    if (we && a == 2'b11) begin
      m_sel = d[1:0]; m_rsrc = d[3:2]; m_ptr = first_of(m_sel);
    end else begin
      counted = (we && a == 2'b01) || (re && m_rsrc == 2);
      if (we && a == 2'b01) m_reg[m_ptr] = d;
      if (counted) m_ptr = (m_ptr == last_of(m_sel)) ? first_of(m_sel) : m_ptr + 1;
    end
    check_all(req);
  endtask

  task automatic ctl(input string req, input int s, input int r);
    op(req, 1'b1, 2'b11, 14'({r[1:0], s[1:0]}), 1'b0);
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    m_reg[0] = 14'h2000; m_reg[1] = 14'h2000;
    for (int i = 2; i < 10; i++) m_reg[i] = '0;
    m_ptr = 0; m_sel = 0; m_rsrc = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");
    // R3: full walk with writes, wrap after DAC 8
    ctl("R2", 0, 0);
    for (int i = 0; i < 10; i++) op("R3/R6", 1'b1, 2'b01, 14'(16'h100 + i), 1'b0);
    chk("R3", cal_ptr, 0);
    // R7: reads ignored with read source 00, counted with 10
    op("R7", 1'b0, 2'b00, '0, 1'b1);
    ctl("R2", 0, 2);
    for (int i = 0; i < 10; i++) op("R3/R8", 1'b0, 2'b00, '0, 1'b1);
    // R4
    ctl("R2", 1, 2);
    repeat (3) op("R4", 1'b0, 2'b00, '0, 1'b1);
    // R5
    ctl("R2", 2, 2);
    chk("R5", cal_ptr, 1);
    repeat (2) op("R5", 1'b1, 2'b01, 14'h1abc, 1'b0);
    ctl("R2", 3, 0);
    repeat (2) op("R5", 1'b1, 2'b01, 14'h0777, 1'b0);
    // R9: abandon midway, same selection
    ctl("R9", 0, 2);
    repeat (4) op("R9", 1'b0, 2'b00, '0, 1'b1);
    ctl("R9", 0, 2);
    chk("R9", cal_ptr, 0);
    // R10
    op("R10", 1'b1, 2'b00, 14'h3fff, 1'b0);
    op("R10", 1'b1, 2'b10, 14'h3fff, 1'b0);
    // R11
    op("R11", 1'b1, 2'b01, 14'h0155, 1'b1);
    op("R11", 1'b1, 2'b11, 14'h0009, 1'b1);
    // random mix
    for (int n = 0; n < 600; n++) begin
      int k;
      k = $urandom % 10;
      case (k)
        0:       ctl("R2/R9", $urandom % 4, ($urandom % 2) ? 2 : $urandom % 4);
        1, 2:    op("R6", 1'b1, 2'b01, 14'($urandom), 1'b0);
        3, 4, 5: op("R7", 1'b0, 2'b00, '0, 1'b1);
        6:       op("R10", 1'b1, ($urandom % 2) ? 2'b00 : 2'b10, 14'($urandom), $urandom % 2);
        7:       op("R11", 1'b1, 2'b01, 14'($urandom), 1'b1);
        default: op("R8", 1'b0, 2'b00, '0, 1'b0);
      endcase
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule